// File: doc/BRIEF.md
# Serial Command and Status Port for a Power Switch Controller

This block is the serial front end of a smart power switch. A host microcontroller sends one 8-bit command per frame. The frame is framed by an active-low chip select and clocked by a serial clock. In the same frame the block shifts back one status byte. All three serial inputs are brought into the system clock domain through two-flop synchronisers. Every edge is then detected there, so the system clock must run at least four times faster than the serial clock.

A status byte arrives on a parallel port. It is frozen into the output shifter at the moment chip select goes low, and its top bit appears on the serial output straight away. Command bits are taken on falling serial clock edges and status bits move on rising ones, so the host reads each status bit on the falling edge that follows. Nothing is written until chip select returns high. At that point a frame of exactly eight bits is split into a 4-bit register address (upper nibble) and a 4-bit data value (lower nibble), and both are presented with a one-cycle write strobe. A frame of any other length is dropped and raises a frame-error flag.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, so_oe_o, so_o, wr_en_o and frame_err_o are low, and wr_addr_o and wr_data_o are zero.
- R2: While chip select is low, si_i is sampled on each falling edge of sclk_i and shifted in most significant bit first. The first bit received becomes bit 7 of the command word.
- R3: On the falling edge of cs_ni the block captures status_i and enables the serial output. Status bit 7 is then driven on so_o before any rising edge of sclk_i.
- R4: Each rising edge of sclk_i that follows at least one falling edge in the frame advances so_o to the next lower status bit. A host sampling so_o just before each falling edge therefore reads status bits 7 down to 0 in order.
- R5: When cs_ni rises after exactly 8 falling sclk_i edges, wr_en_o pulses high for exactly one system clock cycle. During that pulse wr_addr_o carries command bits 7..4 and wr_data_o carries bits 3..0, and both hold their values until the next committed frame.
- R6: While cs_ni is high, so_oe_o and so_o are low, and activity on sclk_i and si_i causes no write and does not change wr_addr_o or wr_data_o.
- R7: When cs_ni rises after any number of falling edges other than 8 (including 0 and more than 8), no write strobe is issued and frame_err_o goes high. frame_err_o stays high until a correctly sized frame is committed, which clears it.
- R8: No write strobe is issued while cs_ni is low.
- R9: Changes on status_i after the falling edge of cs_ni do not affect the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| si_i | input | 1 | Serial command data from host |
| cs_ni | input | 1 | Chip select, active low |
| status_i | input | 8 | Parallel status byte captured at frame start |
| so_o | output | 1 | Serial status data |
| so_oe_o | output | 1 | Output enable for the external tri-state driver on so_o |
| wr_addr_o | output | 4 | Register address of the last committed command |
| wr_data_o | output | 4 | Data of the last committed command |
| wr_en_o | output | 1 | One-cycle write strobe at commit |
| frame_err_o | output | 1 | Set by a wrongly sized frame, cleared by a good one |

## Verification
Three frame lengths are aimed at: 7 and 9 bits, and a frame with no clocks at all. A counter that commits on the eighth edge, or that wraps instead of saturating, would strobe a write for one of these. The bench also toggles sclk_i and si_i with chip select high. A design that listened then would shift in stray bits or drive so_o. Status_i is changed in the middle of some frames, which catches a transmitter that reloads from the live input instead of its snapshot. The status bit read on the first falling edge exposes a shifter that moves on the first rising edge and so loses status bit 7.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int PIN_SCLK = 0;
  localparam int PIN_SI   = 1;
  localparam int PIN_CS   = 2;
  localparam int NUM_PINS = 3;

  typedef struct packed {
    logic sclk_rise;
    logic sclk_fall;
    logic cs_rise;
    logic cs_fall;
    logic si;
  } spi_evt_t;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int                WIDTH   = 3,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= {STAGES{RST_VAL[g]}};
        prev_q[g] <= RST_VAL[g];
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        prev_q[g] <= chain_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q[g];
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q[g];

    AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rise_o[g], fall_o[g]})); // R2
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  spi_evt_t          evt_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_en_o,
  output logic              frame_err_o
);
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int CNT_MAX    = FRAME_BITS + 1;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  logic [FRAME_BITS-1:0] shreg_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  len_ok;

  assign len_ok = (cnt_q == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (evt_i.cs_fall) begin
      cnt_q <= '0;
    end else if (evt_i.sclk_fall) begin
      shreg_q <= {shreg_q[FRAME_BITS-2:0], evt_i.si};
      // saturate so long frames never alias to a legal length
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_en_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (evt_i.cs_rise) begin
        if (len_ok) begin
          wr_addr_o   <= shreg_q[FRAME_BITS-1 -: ADDR_W];
          wr_data_o   <= shreg_q[DATA_W-1:0];
          wr_en_o     <= 1'b1;
          frame_err_o <= 1'b0;
        end else begin
          frame_err_o <= 1'b1;
        end
      end
    end
  end

  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R5
  AST_WR_AFTER_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(evt_i.cs_rise)); // R8
  AST_WR_NOT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !frame_err_o); // R7
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.cs_fall |=> (cnt_q == '0)); // R2
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.cs_rise && !len_ok) |=> (frame_err_o && !wr_en_o)); // R7
endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  spi_evt_t              evt_i,
  input  logic [FRAME_BITS-1:0] status_i,
  output logic                  so_o,
  output logic                  so_oe_o
);
  logic [FRAME_BITS-1:0] shreg_q;
  logic                  started_q;
  logic                  oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q   <= '0;
      started_q <= 1'b0;
      oe_q      <= 1'b0;
    end else if (evt_i.cs_fall) begin
      shreg_q   <= status_i;
      started_q <= 1'b0;
      oe_q      <= 1'b1;
    end else if (evt_i.cs_rise) begin
      oe_q <= 1'b0;
    end else begin
      if (evt_i.sclk_fall) started_q <= 1'b1;
      // first rise of a frame leaves bit 7 in place for the first host sample
      if (evt_i.sclk_rise && started_q) shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign so_o    = oe_q & shreg_q[FRAME_BITS-1];
  assign so_oe_o = oe_q;

  AST_STATUS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.cs_fall |=> (shreg_q == $past(status_i))); // R3
  AST_SO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !so_oe_o |-> !so_o); // R6
  AST_FIRST_RISE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.sclk_rise && !started_q && !evt_i.cs_fall) |=> $stable(shreg_q)); // R4
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_BITS = ADDR_W + DATA_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  si_i,
  input  logic                  cs_ni,
  input  logic [FRAME_BITS-1:0] status_i,
  output logic                  so_o,
  output logic                  so_oe_o,
  output logic [ADDR_W-1:0]     wr_addr_o,
  output logic [DATA_W-1:0]     wr_data_o,
  output logic                  wr_en_o,
  output logic                  frame_err_o
);
  localparam logic [NUM_PINS-1:0] PIN_IDLE = NUM_PINS'(1) << PIN_CS;

  logic [NUM_PINS-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  spi_evt_t            evt;
  logic                sel;

  always_comb begin
    pin_raw           = '0;
    pin_raw[PIN_SCLK] = sclk_i;
    pin_raw[PIN_SI]   = si_i;
    pin_raw[PIN_CS]   = cs_ni;
  end

  spi_cmd_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .lvl_o (pin_lvl),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  assign sel = ~pin_lvl[PIN_CS];

  always_comb begin
    evt.sclk_rise = pin_rise[PIN_SCLK] & sel;
    evt.sclk_fall = pin_fall[PIN_SCLK] & sel;
    evt.cs_rise   = pin_rise[PIN_CS];
    evt.cs_fall   = pin_fall[PIN_CS];
    evt.si        = pin_lvl[PIN_SI];
  end

  spi_cmd_rx #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_en_o    (wr_en_o),
    .frame_err_o(frame_err_o)
  );

  spi_cmd_tx #(
    .FRAME_BITS(FRAME_BITS)
  ) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .status_i(status_i),
    .so_o    (so_o),
    .so_oe_o (so_oe_o)
  );

  AST_NO_WR_WHILE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !evt.cs_fall && $past(sel)) |-> !wr_en_o); // R8
  AST_IDLE_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && !evt.cs_rise && !wr_en_o) |=> $stable(wr_addr_o) && $stable(wr_data_o)); // R6
endmodule

// File: tb/test_spi_cmd_slave.sv
`timescale 1ns/1ps
module test_spi_cmd_slave;
  localparam int HALF = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b0;
  logic       si_i = 1'b0;
  logic       cs_ni = 1'b1;
  logic [7:0] status_i = 8'h00;
  logic       so_o, so_oe_o, wr_en_o, frame_err_o;
  logic [3:0] wr_addr_o, wr_data_o;

  int   checks = 0;
  int   errors = 0;
  int   wr_seen = 0;
  bit   done = 1'b0;
  logic [3:0] exp_addr = 4'h0;
  logic [3:0] exp_data = 4'h0;
  logic       exp_err = 1'b0;

  spi_cmd_slave i_spi_cmd_slave (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .si_i(si_i), .cs_ni(cs_ni),
    .status_i(status_i), .so_o(so_o), .so_oe_o(so_oe_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_en_o(wr_en_o), .frame_err_o(frame_err_o)
  );

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) if (wr_en_o) wr_seen <= wr_seen + 1;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run_frame(input int nbits, input logic [7:0] word,
                           input logic [7:0] st, input bit perturb);
    int base;
    status_i = st;
    wait_clk(2);
    cs_ni = 1'b0;
    wait_clk(HALF);
    chk("R3 status bit 7 before first rise", so_o, st[7]);
    chk("R3 output enabled", so_oe_o, 1'b1);
    if (perturb) status_i = ~st;
    base = wr_seen;
    for (int i = 0; i < nbits; i++) begin
      si_i = word[7 - (i % 8)];
      sclk_i = 1'b1;
      wait_clk(HALF);
      if (i < 8) chk(perturb ? "R9 snapshot bit" : "R4 status bit", so_o, st[7 - i]);
      sclk_i = 1'b0;
      wait_clk(HALF);
    end
    chk("R8 no write while selected", wr_seen - base, 0);
    cs_ni = 1'b1;
    wait_clk(HALF);
    if (nbits == 8) begin
      exp_addr = word[7:4];
      exp_data = word[3:0];
      exp_err  = 1'b0;
      chk("R5 one strobe", wr_seen - base, 1);
    end else begin
      exp_err = 1'b1;
      chk("R7 no strobe on bad length", wr_seen - base, 0);
    end
    chk("R2/R5 address", wr_addr_o, exp_addr);
    chk("R2/R5 data", wr_data_o, exp_data);
    chk("R7 frame error", frame_err_o, exp_err);
    chk("R6 output disabled", so_oe_o, 1'b0);
    chk("R6 output low", so_o, 1'b0);
  endtask

  task automatic idle_noise(input int n);
    int base;
    base = wr_seen;
    for (int i = 0; i < n; i++) begin
      si_i = 1'($urandom);
      sclk_i = 1'b1;
      wait_clk(HALF);
      chk("R6 no drive when idle", {so_oe_o, so_o}, 2'b00);
      sclk_i = 1'b0;
      wait_clk(HALF);
    end
    si_i = 1'b0;
    wait_clk(HALF);
    chk("R6 no write from idle clocks", wr_seen - base, 0);
    chk("R6 address kept", wr_addr_o, exp_addr);
    chk("R6 data kept", wr_data_o, exp_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    wait_clk(4);
    chk("R1 oe after reset", so_oe_o, 1'b0);
    chk("R1 so after reset", so_o, 1'b0);
    chk("R1 strobe after reset", wr_en_o, 1'b0);
    chk("R1 error after reset", frame_err_o, 1'b0);
    chk("R1 fields after reset", {wr_addr_o, wr_data_o}, 8'h00);
    rst_ni = 1'b1;
    wait_clk(4);

    run_frame(8, 8'hA5, 8'h81, 1'b0);
    run_frame(8, 8'h3C, 8'h7E, 1'b1);
    run_frame(7, 8'hF0, 8'hC3, 1'b0);
    run_frame(8, 8'h12, 8'h55, 1'b0);
    run_frame(9, 8'hE7, 8'hAA, 1'b0);
    idle_noise(12);
    run_frame(0, 8'h00, 8'hFF, 1'b0);
    run_frame(8, 8'h00, 8'h00, 1'b0);
    run_frame(8, 8'hFF, 8'hFF, 1'b1);

    for (int k = 0; k < 30; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      run_frame((r < 7) ? 8 : (r == 7 ? 7 : (r == 8 ? 9 : 3)),
                8'($urandom), 8'($urandom), 1'($urandom));
      if (k % 10 == 9) idle_noise(4);
    end

    done = 1'b1;
    report();
  end
endmodule